// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

This block is the control unit and datapath of a small accumulator machine, built as a fixed state machine. Every clock it performs one group of register transfers. It holds a program counter, a memory address register, a memory buffer register, an instruction register and one accumulator, and it has a single adder that these registers share. Each instruction passes through a fetch cycle. An indirect cycle follows only when the instruction word asks for one. Then comes the execute cycle. An interrupt cycle follows only when a request is pending and interrupts are enabled.

Memory is one external port with one address. Read data must be valid during the step that follows the step in which the address register was loaded. A write happens at the clock edge that ends a step with the write strobe high. A word is 16 bits:

- Bit 15 is the indirect flag.
- Bits 14:12 are the opcode: 0 add, 1 increment-and-skip-if-zero, 2 call-and-save-return, 3 interrupt enable, 7 halt. Codes 4 to 6 do nothing.
- Bits 11:0 are the operand address.

A halt output, together with the program counter and accumulator outputs, lets a test read the final state.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, pc_o and acc_o are 0, halt_o and both memory strobes are 0, and int_en_o is 1.
- R2: Fetch takes three clocks: load address from PC; read memory (mem_rd_o high, address = PC) while PC increments; copy the word into the instruction register.
- R3: For opcodes 0, 1 and 2 with bit 15 set, three extra clocks read the word at the address field, and its bits 11:0 become the operand address. The indirect flag is cleared.
- R4: Opcode 0 adds the word at the operand address into the accumulator, modulo 2^16. It takes three execute clocks, so a direct add runs in 6 clocks.
- R5: Opcode 1 takes four execute clocks. It reads the operand, increments it and writes it back in the fourth clock. If the new value is 0, PC is incremented once more, which skips the next instruction.
- R6: Opcode 2 writes the address of the next instruction to the operand address X and then continues at X+1. It takes three execute clocks.
- R7: Opcode 7 takes one execute clock. It then holds halt_o high with no memory traffic and a frozen PC until reset.
- R8: At the end of an execute cycle with irq_i high and interrupts enabled, a three-clock interrupt cycle writes PC to address 0. PC becomes 1 and interrupts are disabled.
- R9: While interrupts are disabled, irq_i has no effect. Opcode 3 takes one execute clock and re-enables interrupts in time for the request check at its own end.
- R10: mem_rd_o and mem_wr_o are never high in the same clock.
- R11: For opcodes 3 to 7 the indirect flag is ignored. Opcodes 4 to 6 take one execute clock and change neither the accumulator nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request level |
| mem_rdata_i | input | 16 | Read data for mem_addr_o |
| mem_addr_o | output | 12 | Memory address (address register) |
| mem_wdata_o | output | 16 | Write data (buffer register) |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| halt_o | output | 1 | Halted |
| int_en_o | output | 1 | Interrupt enable flag |

## Verification
The assertions assume that memory returns the addressed word combinationally during the step after the address load. They also assume that irq_i changes only away from the rising edge. The bench meets the first assumption with a memory model that reads asynchronously from mem_addr_o. It meets the second by driving irq_i only on falling edges. In the re-enable scenario it drops the request after the second save write, so the handler does not loop forever.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [2:0] {PH_FETCH, PH_INDIR, PH_EXEC, PH_INTR, PH_HALT} phase_e;

  localparam int unsigned OPW = 3;
  localparam logic [OPW-1:0] OP_ADD  = 3'd0;
  localparam logic [OPW-1:0] OP_ISZ  = 3'd1;
  localparam logic [OPW-1:0] OP_BSA  = 3'd2;
  localparam logic [OPW-1:0] OP_ION  = 3'd3;
  localparam logic [OPW-1:0] OP_HALT = 3'd7;

  typedef enum logic [1:0] {MAR_KEEP, MAR_PC, MAR_IR, MAR_SAVE} mar_src_e;
  typedef enum logic [1:0] {MBR_KEEP, MBR_MEM, MBR_PC, MBR_SUM} mbr_src_e;
  typedef enum logic [2:0] {PC_KEEP, PC_SUM, PC_IR, PC_VEC, PC_SUM_Z} pc_src_e;
  typedef enum logic [1:0] {IR_KEEP, IR_WORD, IR_ADDR} ir_src_e;
  typedef enum logic [1:0] {ADD_PC1, ADD_MBR1, ADD_ACC_MBR} add_src_e;

  typedef struct packed {
    mar_src_e mar;
    mbr_src_e mbr;
    pc_src_e  pc;
    ir_src_e  ir;
    add_src_e add;
    logic     acc_ld;
    logic     rd;
    logic     wr;
    logic     ie_set;
    logic     ie_clr;
  } uop_t;

  function automatic logic uses_operand(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_ISZ) || (op == OP_BSA);
  endfunction
endpackage

// File: rtl/hwc_seq.sv
module hwc_seq
  import hwc_pkg::*;
#(
  parameter int unsigned STW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           irq_i,
  input  logic [OPW-1:0] new_op_i,
  input  logic           new_ind_i,
  input  logic [OPW-1:0] op_i,
  input  logic           ind_i,
  output uop_t           uop_o,
  output phase_e         phase_o,
  output logic [STW-1:0] step_o,
  output logic           ie_o
);
  phase_e         phase_q, phase_d;
  logic [STW-1:0] step_q, step_d;
  logic           ie_q, ie_d;
  logic           last;

  always_comb begin
    uop_o   = '0;
    last    = 1'b0;
    phase_d = phase_q;
    step_d  = step_q + 1'b1;
    unique case (phase_q)
      PH_FETCH: begin
        unique case (step_q)
          2'd0: uop_o.mar = MAR_PC;
          2'd1: begin
            uop_o.mbr = MBR_MEM;
            uop_o.rd  = 1'b1;
            uop_o.pc  = PC_SUM;
            uop_o.add = ADD_PC1;
          end
          default: begin
            uop_o.ir = IR_WORD;
            step_d   = '0;
            phase_d  = (new_ind_i && uses_operand(new_op_i)) ? PH_INDIR : PH_EXEC;
          end
        endcase
      end
      PH_INDIR: begin
        unique case (step_q)
          2'd0: uop_o.mar = MAR_IR;
          2'd1: begin
            uop_o.mbr = MBR_MEM;
            uop_o.rd  = 1'b1;
          end
          default: begin
            uop_o.ir = IR_ADDR;
            step_d   = '0;
            phase_d  = PH_EXEC;
          end
        endcase
      end
      PH_EXEC: begin
        if (uses_operand(op_i)) begin
          unique case (step_q)
            2'd0: begin
              uop_o.mar = MAR_IR;
              if (op_i == OP_BSA) uop_o.mbr = MBR_PC;
            end
            2'd1: begin
              if (op_i == OP_BSA) begin
                uop_o.pc = PC_IR;
                uop_o.wr = 1'b1;
              end else begin
                uop_o.mbr = MBR_MEM;
                uop_o.rd  = 1'b1;
              end
            end
            2'd2: begin
              if (op_i == OP_ADD) begin
                uop_o.add    = ADD_ACC_MBR;
                uop_o.acc_ld = 1'b1;
                last         = 1'b1;
              end else if (op_i == OP_ISZ) begin
                uop_o.add = ADD_MBR1;
                uop_o.mbr = MBR_SUM;
              end else begin
                uop_o.add = ADD_PC1;
                uop_o.pc  = PC_SUM;
                last      = 1'b1;
              end
            end
            default: begin
              uop_o.wr  = 1'b1;
              uop_o.add = ADD_PC1;
              uop_o.pc  = PC_SUM_Z;
              last      = 1'b1;
            end
          endcase
        end else if (op_i == OP_HALT) begin
          phase_d = PH_HALT;
          step_d  = '0;
        end else begin
          uop_o.ie_set = (op_i == OP_ION);
          last         = 1'b1;
        end
        if (last) begin
          step_d  = '0;
          phase_d = (irq_i && (ie_q || uop_o.ie_set)) ? PH_INTR : PH_FETCH;
        end
      end
      PH_INTR: begin
        unique case (step_q)
          2'd0: uop_o.mbr = MBR_PC;
          2'd1: begin
            uop_o.mar    = MAR_SAVE;
            uop_o.pc     = PC_VEC;
            uop_o.ie_clr = 1'b1;
          end
          default: begin
            uop_o.wr = 1'b1;
            step_d   = '0;
            phase_d  = PH_FETCH;
          end
        endcase
      end
      default: step_d = '0;
    endcase
  end

  always_comb begin
    ie_d = ie_q;
    if (uop_o.ie_set) ie_d = 1'b1;
    if (uop_o.ie_clr) ie_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      step_q  <= '0;
      ie_q    <= 1'b1;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      ie_q    <= ie_d;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign ie_o    = ie_q;

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uop_o.rd && uop_o.wr));

  // R3
  ind_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && uses_operand(op_i)) |-> !ind_i);
endmodule

// File: rtl/hwc_dpath.sv
module hwc_dpath
  import hwc_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 12,
  parameter int unsigned SAVE_ADDR = 0,
  parameter int unsigned VEC_ADDR  = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  uop_t           uop_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic [AW-1:0]  pc_o,
  output logic [DW-1:0]  acc_o,
  output logic [OPW-1:0] ir_op_o,
  output logic           ir_ind_o,
  output logic [OPW-1:0] mbr_op_o,
  output logic           mbr_ind_o
);
  localparam int unsigned OP_HI = DW - 2;
  localparam int unsigned OP_LO = DW - 1 - OPW;

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mbr_q, ir_q, acc_q;
  logic [DW-1:0] add_a, add_b, sum;

  // the one shared adder
  always_comb begin
    unique case (uop_i.add)
      ADD_MBR1: begin add_a = mbr_q; add_b = DW'(1); end
      ADD_ACC_MBR: begin add_a = acc_q; add_b = mbr_q; end
      default: begin add_a = DW'(pc_q); add_b = DW'(1); end
    endcase
    sum = add_a + add_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      unique case (uop_i.mar)
        MAR_PC:   mar_q <= pc_q;
        MAR_IR:   mar_q <= ir_q[AW-1:0];
        MAR_SAVE: mar_q <= AW'(SAVE_ADDR);
        default:  ;
      endcase
      unique case (uop_i.mbr)
        MBR_MEM: mbr_q <= mem_rdata_i;
        MBR_PC:  mbr_q <= DW'(pc_q);
        MBR_SUM: mbr_q <= sum;
        default: ;
      endcase
      unique case (uop_i.pc)
        PC_SUM:   pc_q <= sum[AW-1:0];
        PC_IR:    pc_q <= ir_q[AW-1:0];
        PC_VEC:   pc_q <= AW'(VEC_ADDR);
        PC_SUM_Z: if (mbr_q == '0) pc_q <= sum[AW-1:0];
        default:  ;
      endcase
      unique case (uop_i.ir)
        IR_WORD: ir_q <= mbr_q;
        IR_ADDR: ir_q <= {1'b0, ir_q[DW-2:AW], mbr_q[AW-1:0]};
        default: ;
      endcase
      if (uop_i.acc_ld) acc_q <= sum;
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign pc_o        = pc_q;
  assign acc_o       = acc_q;
  assign ir_op_o     = ir_q[OP_HI:OP_LO];
  assign ir_ind_o    = ir_q[DW-1];
  assign mbr_op_o    = mbr_q[OP_HI:OP_LO];
  assign mbr_ind_o   = mbr_q[DW-1];

  // R5
  skip_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_i.pc == PC_SUM_Z && mbr_q != '0) |=> pc_q == $past(pc_q));
endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import hwc_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 12,
  parameter int unsigned SAVE_ADDR = 0,
  parameter int unsigned VEC_ADDR  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          halt_o,
  output logic          int_en_o
);
  localparam int unsigned STW = 2;

  uop_t           uop;
  phase_e         phase;
  logic [STW-1:0] step;
  logic [OPW-1:0] ir_op, mbr_op;
  logic           ir_ind, mbr_ind;

  hwc_seq #(.STW(STW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .new_op_i  (mbr_op),
    .new_ind_i (mbr_ind),
    .op_i      (ir_op),
    .ind_i     (ir_ind),
    .uop_o     (uop),
    .phase_o   (phase),
    .step_o    (step),
    .ie_o      (int_en_o)
  );

  hwc_dpath #(.DW(DW), .AW(AW), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uop_i       (uop),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_o        (pc_o),
    .acc_o       (acc_o),
    .ir_op_o     (ir_op),
    .ir_ind_o    (ir_ind),
    .mbr_op_o    (mbr_op),
    .mbr_ind_o   (mbr_ind)
  );

  assign mem_rd_o = uop.rd;
  assign mem_wr_o = uop.wr;
  assign halt_o   = (phase == PH_HALT);

  // R2
  fetch_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FETCH && step == 2'd2) |-> $past(mem_rd_o));

  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && $stable(pc_o) && !mem_rd_o && !mem_wr_o));

  // R8
  intr_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_INTR && step == 2'd2) |-> (mem_wr_o && mem_addr_o == AW'(SAVE_ADDR)));

  // R9
  intr_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_INTR && step == 2'd0) |-> int_en_o);
endmodule

// File: tb/instr_cycle_ctrl_tb_top.sv
module instr_cycle_ctrl_tb_top;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] rdata, wdata, acc;
  logic [11:0] addr, pc;
  logic        rd, wr, halt, ie;
  logic [15:0] mem [4096];
  int total = 0;
  int bad = 0;
  int excl_viol = 0;

  always #10 clk = ~clk;

  instr_cycle_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mem_rdata_i(rdata),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rd_o(rd), .mem_wr_o(wr),
    .pc_o(pc), .acc_o(acc), .halt_o(halt), .int_en_o(ie)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (wr) mem[addr] <= wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    irq   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mem[i] = '0;
  endtask

  task automatic run_prog(input int drop_after, output int cyc, output int rds);
    int saves = 0;
    cyc = 0;
    rds = 0;
    rst_n = 1'b1;
    while (1) begin
      if (rd) rds++;
      if (rd && wr) excl_viol++;
      if (wr && addr == 12'd0) begin
        saves++;
        if (saves == drop_after) irq = 1'b0;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halt) break;
      if (cyc > 2000) begin
        chk("R7 run timeout", 32'(cyc), 0);
        break;
      end
    end
  endtask

  task automatic halt_quiet(input string tag);
    logic [11:0] p = pc;
    int traffic = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rd || wr) traffic++;
    end
    chk({tag, " R7 traffic"}, 32'(traffic), 0);
    chk({tag, " R7 pc frozen"}, 32'(pc), 32'(p));
    chk({tag, " R7 halt held"}, 32'(halt), 1);
  endtask

  task automatic t_reset();
    hold_reset();
    chk("R1 pc", 32'(pc), 0);
    chk("R1 acc", 32'(acc), 0);
    chk("R1 halt", 32'(halt), 0);
    chk("R1 int_en", 32'(ie), 1);
    chk("R1 strobes", 32'({rd, wr}), 0);
  endtask

  task automatic t_add();
    int c, r;
    hold_reset();
    mem[0] = 16'h0100; mem[1] = 16'h0101; mem[2] = 16'h7000;
    mem[12'h100] = 16'd5; mem[12'h101] = 16'hFFFE;
    run_prog(0, c, r);
    chk("R4 acc wrap", 32'(acc), 3);
    chk("R4 cycles", 32'(c), 16);
    chk("R2 reads", 32'(r), 5);
    chk("R2 pc", 32'(pc), 3);
    halt_quiet("add");
  endtask

  task automatic t_indirect_add();
    int c, r;
    hold_reset();
    mem[0] = 16'h8050; mem[1] = 16'h7000;
    mem[12'h050] = 16'h0120; mem[12'h120] = 16'd7;
    run_prog(0, c, r);
    chk("R3 acc", 32'(acc), 7);
    chk("R3 cycles", 32'(c), 13);
    chk("R3 reads", 32'(r), 4);
  endtask

  task automatic t_isz();
    int c, r;
    hold_reset();
    mem[0] = 16'h1200; mem[1] = 16'h7000; mem[12'h200] = 16'd4;
    run_prog(0, c, r);
    chk("R5 incr", 32'(mem[12'h200]), 5);
    chk("R5 no skip pc", 32'(pc), 2);
    chk("R5 cycles", 32'(c), 11);
    hold_reset();
    mem[0] = 16'h1200; mem[1] = 16'h0201; mem[2] = 16'h7000;
    mem[12'h200] = 16'hFFFF; mem[12'h201] = 16'd9;
    run_prog(0, c, r);
    chk("R5 wrap to zero", 32'(mem[12'h200]), 0);
    chk("R5 skipped acc", 32'(acc), 0);
    chk("R5 skip pc", 32'(pc), 3);
    chk("R5 skip cycles", 32'(c), 11);
  endtask

  task automatic t_bsa(input logic ind);
    int c, r;
    hold_reset();
    mem[0] = ind ? 16'hA040 : 16'h2300;
    mem[12'h040] = 16'h0300;
    mem[12'h300] = 16'hDEAD; mem[12'h301] = 16'h0310; mem[12'h302] = 16'h7000;
    mem[12'h310] = 16'd11;
    run_prog(0, c, r);
    chk(ind ? "R3 R6 saved return" : "R6 saved return", 32'(mem[12'h300]), 1);
    chk("R6 continued at X+1", 32'(acc), 11);
    chk("R6 pc", 32'(pc), 32'h303);
    chk("R6 cycles", 32'(ind ? 19 : 16), 32'(c));
  endtask

  task automatic t_irq_once();
    int c, r;
    hold_reset();
    mem[0] = 16'h0100; mem[1] = 16'h0101; mem[2] = 16'h7000;
    mem[12'h100] = 16'd2; mem[12'h101] = 16'd3;
    irq = 1'b1;
    run_prog(0, c, r);
    chk("R8 saved pc", 32'(mem[0]), 1);
    chk("R8 disabled", 32'(ie), 0);
    chk("R9 acc", 32'(acc), 5);
    chk("R8 cycles", 32'(c), 19);
    halt_quiet("irq");
    irq = 1'b0;
  endtask

  task automatic t_irq_reenable();
    int c, r;
    hold_reset();
    mem[0] = 16'h0100; mem[1] = 16'h0101; mem[2] = 16'h0101;
    mem[3] = 16'h3000; mem[4] = 16'h7000;
    mem[12'h100] = 16'd2; mem[12'h101] = 16'd3;
    irq = 1'b1;
    run_prog(2, c, r);
    chk("R9 acc", 32'(acc), 14);
    chk("R9 second save", 32'(mem[0]), 4);
    chk("R9 re-enabled", 32'(ie), 1);
    chk("R9 pc", 32'(pc), 5);
    chk("R9 cycles", 32'(c), 48);
  endtask

  task automatic t_unused();
    int c, r;
    hold_reset();
    mem[0] = 16'hC123; mem[1] = 16'hF000; mem[12'h123] = 16'h5A5A;
    run_prog(0, c, r);
    chk("R11 acc", 32'(acc), 0);
    chk("R11 mem", 32'(mem[12'h123]), 32'h5A5A);
    chk("R11 cycles", 32'(c), 8);
    chk("R11 reads", 32'(r), 2);
    chk("R11 pc", 32'(pc), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=expired exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_indirect_add();
    t_isz();
    t_bsa(1'b0);
    t_bsa(1'b1);
    t_irq_once();
    t_irq_reenable();
    t_unused();
    chk("R10 rd/wr overlap", 32'(excl_viol), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule